// File: doc/BRIEF.md
# Miss and Write Buffer Allocator

This block keeps the outstanding-request bookkeeping that sits beside a cache. It has two small queues. The miss queue holds cacheable misses and uncached reads. The write-back queue holds writes. An allocation request carries an address, a size, a kind and an optional flag that asks for the memory bus. The block picks the lowest free slot in the target queue and stores the entry there. Each stored entry gets a global order tag. When the memory side issues an entry, the entry is marked in service. The memory side frees the entry later by its index.

Each queue owns one bit of a blocked mask: bit 0 for the miss queue and bit 1 for the write-back queue. An allocation that fills the last waiting slot of its queue sets that queue's bit. The bit clears only when an issue takes the queue from full to not full. Freeing an entry never clears it. The CPU side sees a stall while any bit is set. It sees a one-cycle retry pulse once the mask drains, if a request was turned away during the stall. For each cause the block counts block events and accumulates the number of cycles spent blocked.

Top module: `miss_wb_alloc`

## Requirements
- R1: An accepted allocation of kind 2'b00 (cacheable miss) goes to queue 0. It stores the address with the low log2(BLK_BYTES) bits cleared, and a size equal to BLK_BYTES.
- R2: An accepted allocation of kind 2'b01 (uncached read) goes to queue 0 and stores the request address and size unchanged.
- R3: An accepted allocation of kind 2'b10 (write) goes to queue 1 and stores the request address and size unchanged.
- R4: The order tag starts at 0 after reset. Each accepted allocation takes the current tag, then the tag advances by one. The tag appears on alloc_tag and in the stored entry.
- R5: An allocation that makes every slot of its queue valid and not in service sets mask bit q, where q is 0 for the miss queue and 1 for the write-back queue. cpu_stall is high whenever the mask is nonzero.
- R6: An accepted allocation with alloc_bus_req high produces a one-cycle mem_req. mem_req_cause carries the queue number. Without the flag, mem_req stays low.
- R7: Issuing a valid waiting entry marks it in service. The issue clears that queue's mask bit only if the queue was full before the issue. An issue to a queue that was not full leaves the mask unchanged.
- R8: A free removes an entry only if that entry is in service. A free aimed at a waiting entry is ignored. A free never changes the mask.
- R9: An allocation is rejected when its queue has no free slot or its kind is 2'b11. A rejection gives a one-cycle alloc_err, stores nothing and does not advance the tag. Acceptance gives a one-cycle alloc_ack with the slot index.
- R10: If an allocation was rejected while the mask was nonzero, cpu_retry pulses for one cycle in the same cycle the mask returns to zero. Otherwise cpu_retry stays low.
- R11: Each time a mask bit is set, that cause's event counter increments by one. When the bit clears, that cause's cycle total grows by the number of clock edges from the setting edge to the clearing edge.
- R12: After reset all entries are invalid, the mask and all counters are zero, and stall, retry, ack, err and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 00 cacheable miss, 01 uncached read, 10 write, 11 illegal |
| alloc_addr | input | AW | Request address |
| alloc_size | input | SW | Request size in bytes |
| alloc_bus_req | input | 1 | Ask for the memory bus on acceptance |
| alloc_ack | output | 1 | Allocation accepted (registered pulse) |
| alloc_err | output | 1 | Allocation rejected (registered pulse) |
| alloc_slot | output | IW | Slot taken by the accepted allocation |
| alloc_tag | output | TAG_W | Order tag given to the accepted allocation |
| issue_valid | input | 1 | Mark an entry in service |
| issue_q | input | 1 | Queue of the issued entry |
| issue_idx | input | IW | Slot of the issued entry |
| free_valid | input | 1 | Free an entry |
| free_q | input | 1 | Queue of the freed entry |
| free_idx | input | IW | Slot of the freed entry |
| rd_q | input | 1 | Inspection queue select |
| rd_idx | input | IW | Inspection slot select |
| rd_valid | output | 1 | Selected entry is valid |
| rd_busy | output | 1 | Selected entry is in service |
| rd_addr | output | AW | Stored address |
| rd_size | output | SW | Stored size |
| rd_tag | output | TAG_W | Stored order tag |
| blocked_mask | output | 2 | Per-cause blocked bits |
| cpu_stall | output | 1 | CPU side must hold requests |
| cpu_retry | output | 1 | One-cycle retry pulse |
| mem_req | output | 1 | Memory-side request pulse |
| mem_req_cause | output | 1 | Queue behind mem_req |
| miss_blk_events | output | CNT_W | Miss-queue block events |
| wb_blk_events | output | CNT_W | Write-queue block events |
| miss_blk_cycles | output | CNT_W | Cycles the miss queue spent blocked |
| wb_blk_cycles | output | CNT_W | Cycles the write queue spent blocked |

## Verification
The hardest state to reach is a rejection that happens while a queue is blocked. It needs the queue fully waiting, one more allocation turned away, and then the single issue that drains the mask, which must raise cpu_retry in that same cycle. The bench fills the miss queue slot by slot, sends one extra allocation and waits a fixed number of idle cycles before the issue, so the accumulated blocked-cycle total has a known value. A second pass frees an in-service entry so that the queue is again full of valid entries without being blocked. A rejection there must not produce a retry, and an in-service entry still holding its slot must reject allocation with the mask at zero.

// File: rtl/miss_wb_alloc.sv
module miss_wb_alloc #(
  parameter int AW = 32,
  parameter int SW = 7,
  parameter int BLK_BYTES = 64,
  parameter int MISS_SLOTS = 4,
  parameter int WB_SLOTS = 2,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int MAXS = (MISS_SLOTS > WB_SLOTS) ? MISS_SLOTS : WB_SLOTS,
  localparam int IW = (MAXS > 1) ? $clog2(MAXS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [1:0]       alloc_kind,
  input  logic [AW-1:0]    alloc_addr,
  input  logic [SW-1:0]    alloc_size,
  input  logic             alloc_bus_req,
  output logic             alloc_ack,
  output logic             alloc_err,
  output logic [IW-1:0]    alloc_slot,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             issue_valid,
  input  logic             issue_q,
  input  logic [IW-1:0]    issue_idx,
  input  logic             free_valid,
  input  logic             free_q,
  input  logic [IW-1:0]    free_idx,
  input  logic             rd_q,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic             rd_busy,
  output logic [AW-1:0]    rd_addr,
  output logic [SW-1:0]    rd_size,
  output logic [TAG_W-1:0] rd_tag,
  output logic [1:0]       blocked_mask,
  output logic             cpu_stall,
  output logic             cpu_retry,
  output logic             mem_req,
  output logic             mem_req_cause,
  output logic [CNT_W-1:0] miss_blk_events,
  output logic [CNT_W-1:0] wb_blk_events,
  output logic [CNT_W-1:0] miss_blk_cycles,
  output logic [CNT_W-1:0] wb_blk_cycles
);
  localparam logic [AW-1:0] OFS_MASK = AW'(BLK_BYTES - 1);

  logic [MAXS-1:0]  vld [2];
  logic [MAXS-1:0]  busy [2];
  logic [AW-1:0]    e_addr [2][MAXS];
  logic [SW-1:0]    e_size [2][MAXS];
  logic [TAG_W-1:0] e_tag [2][MAXS];
  logic [IW:0]      wcnt [2];
  logic [IW:0]      wnext [2];
  logic [CNT_W-1:0] evt [2];
  logic [CNT_W-1:0] bcyc [2];
  logic [CNT_W-1:0] bstart [2];
  logic [CNT_W-1:0] cyc;
  logic [TAG_W-1:0] tag_ctr;
  logic [1:0]       mask, mask_n, set_b, clr_b, have_free;
  logic [IW-1:0]    fslot [2];
  logic             rej_pend, retry_q;

  function automatic logic [IW:0] qdepth(input logic q);
    return q ? (IW+1)'(WB_SLOTS) : (IW+1)'(MISS_SLOTS);
  endfunction

  wire aq       = (alloc_kind == 2'b10);
  wire kind_ok  = (alloc_kind != 2'b11);
  wire alloc_ok = alloc_valid && kind_ok && have_free[aq];
  wire alloc_no = alloc_valid && !alloc_ok;
  wire issue_ok = issue_valid && ({1'b0, issue_idx} < qdepth(issue_q)) &&
                  vld[issue_q][issue_idx] && !busy[issue_q][issue_idx];
  wire free_ok  = free_valid && ({1'b0, free_idx} < qdepth(free_q)) &&
                  vld[free_q][free_idx] && busy[free_q][free_idx];

  always_comb begin
    for (int q = 0; q < 2; q++) begin
      have_free[q] = 1'b0;
      fslot[q] = '0;
      for (int i = MAXS - 1; i >= 0; i--) begin
        if (((IW+1)'(i) < qdepth(q[0])) && !vld[q][i]) begin
          have_free[q] = 1'b1;
          fslot[q] = IW'(i);
        end
      end
      wnext[q] = wcnt[q] + (IW+1)'(alloc_ok && (aq == q[0]))
                         - (IW+1)'(issue_ok && (issue_q == q[0]));
      set_b[q] = alloc_ok && (aq == q[0]) && (wnext[q] == qdepth(q[0]));
      clr_b[q] = issue_ok && (issue_q == q[0]) && (wcnt[q] == qdepth(q[0])) &&
                 (wnext[q] != qdepth(q[0]));
    end
    mask_n = (mask | set_b) & ~clr_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < 2; q++) begin
        vld[q] <= '0;
        busy[q] <= '0;
        wcnt[q] <= '0;
        evt[q] <= '0;
        bcyc[q] <= '0;
        bstart[q] <= '0;
      end
      cyc <= '0;
      tag_ctr <= '0;
      mask <= '0;
      rej_pend <= 1'b0;
      retry_q <= 1'b0;
      alloc_ack <= 1'b0;
      alloc_err <= 1'b0;
      alloc_slot <= '0;
      alloc_tag <= '0;
      mem_req <= 1'b0;
      mem_req_cause <= 1'b0;
    end else begin
      cyc <= cyc + 1'b1;
      alloc_ack <= alloc_ok;
      alloc_err <= alloc_no;
      mem_req <= alloc_ok && alloc_bus_req;
      if (alloc_ok) begin
        vld[aq][fslot[aq]] <= 1'b1;
        busy[aq][fslot[aq]] <= 1'b0;
        e_addr[aq][fslot[aq]] <= (alloc_kind == 2'b00) ? (alloc_addr & ~OFS_MASK) : alloc_addr;
        e_size[aq][fslot[aq]] <= (alloc_kind == 2'b00) ? SW'(BLK_BYTES) : alloc_size;
        e_tag[aq][fslot[aq]] <= tag_ctr;
        alloc_slot <= fslot[aq];
        alloc_tag <= tag_ctr;
        mem_req_cause <= aq;
        tag_ctr <= tag_ctr + 1'b1;
      end
      if (issue_ok) busy[issue_q][issue_idx] <= 1'b1;
      if (free_ok) begin
        vld[free_q][free_idx] <= 1'b0;
        busy[free_q][free_idx] <= 1'b0;
      end
      for (int q = 0; q < 2; q++) begin
        wcnt[q] <= wnext[q];
        if (set_b[q]) begin
          evt[q] <= evt[q] + 1'b1;
          bstart[q] <= cyc;
        end
        if (clr_b[q]) bcyc[q] <= bcyc[q] + (cyc - bstart[q]);
      end
      mask <= mask_n;
      retry_q <= (mask != 2'b00) && (mask_n == 2'b00) && (rej_pend || alloc_no);
      if ((mask != 2'b00) && (mask_n == 2'b00)) rej_pend <= 1'b0;
      else if (alloc_no && (mask != 2'b00)) rej_pend <= 1'b1;
    end
  end

  assign rd_valid = vld[rd_q][rd_idx];
  assign rd_busy  = busy[rd_q][rd_idx];
  assign rd_addr  = e_addr[rd_q][rd_idx];
  assign rd_size  = e_size[rd_q][rd_idx];
  assign rd_tag   = e_tag[rd_q][rd_idx];
  assign blocked_mask    = mask;
  assign cpu_stall       = |mask;
  assign cpu_retry       = retry_q;
  assign miss_blk_events = evt[0];
  assign wb_blk_events   = evt[1];
  assign miss_blk_cycles = bcyc[0];
  assign wb_blk_cycles   = bcyc[1];
endmodule

// File: rtl/miss_wb_alloc_chk.sv
module miss_wb_alloc_chk #(parameter int CNT_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_bus_req,
  input logic             alloc_ack,
  input logic             alloc_err,
  input logic [1:0]       blocked_mask,
  input logic             cpu_stall,
  input logic             cpu_retry,
  input logic             mem_req,
  input logic [CNT_W-1:0] miss_blk_events
);
  p_ack_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_ack, alloc_err}));
  p_block_needs_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blocked_mask[0]) |-> $past(alloc_valid));
  p_req_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(alloc_valid && alloc_bus_req));
  p_retry_unstalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |-> !cpu_stall);
  p_retry_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |=> !cpu_retry);
  p_event_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blocked_mask[0]) |-> (miss_blk_events == CNT_W'($past(miss_blk_events) + 1'b1)));
endmodule

bind miss_wb_alloc miss_wb_alloc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_bus_req(alloc_bus_req),
  .alloc_ack(alloc_ack), .alloc_err(alloc_err), .blocked_mask(blocked_mask),
  .cpu_stall(cpu_stall), .cpu_retry(cpu_retry), .mem_req(mem_req),
  .miss_blk_events(miss_blk_events)
);

// File: tb/miss_wb_alloc_tb_top.sv
module miss_wb_alloc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_bus_req = 0, issue_valid = 0, issue_q = 0;
  logic free_valid = 0, free_q = 0, rd_q = 0;
  logic [1:0] alloc_kind = 0;
  logic [31:0] alloc_addr = 0;
  logic [6:0] alloc_size = 0;
  logic [1:0] issue_idx = 0, free_idx = 0, rd_idx = 0;
  logic alloc_ack, alloc_err, rd_valid, rd_busy, cpu_stall, cpu_retry, mem_req, mem_req_cause;
  logic [1:0] alloc_slot, blocked_mask;
  logic [7:0] alloc_tag, rd_tag;
  logic [31:0] rd_addr;
  logic [6:0] rd_size;
  logic [15:0] miss_blk_events, wb_blk_events, miss_blk_cycles, wb_blk_cycles;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  miss_wb_alloc dut_i (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic alloc(input logic [1:0] k, input logic [31:0] a, input logic [6:0] s, input logic br);
    alloc_valid = 1; alloc_kind = k; alloc_addr = a; alloc_size = s; alloc_bus_req = br;
    @(posedge clk); #1;
    alloc_valid = 0; alloc_bus_req = 0;
  endtask

  task automatic issue(input logic q, input logic [1:0] i);
    issue_valid = 1; issue_q = q; issue_idx = i;
    @(posedge clk); #1;
    issue_valid = 0;
  endtask

  task automatic free_e(input logic q, input logic [1:0] i);
    free_valid = 1; free_q = q; free_idx = i;
    @(posedge clk); #1;
    free_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic peek(input logic q, input logic [1:0] i);
    rd_q = q; rd_idx = i; #1;
  endtask

  task automatic t_reset();
    idle(3); rst_n = 1; idle(1);
    chk("R12", "mask", blocked_mask, 0);
    chk("R12", "stall/retry/ack/err/req", {cpu_stall, cpu_retry, alloc_ack, alloc_err, mem_req}, 0);
    chk("R12", "counters", {miss_blk_events, wb_blk_events, miss_blk_cycles, wb_blk_cycles}, 0);
    peek(0, 0); chk("R12", "entry invalid", rd_valid, 0);
  endtask

  task automatic t_kinds();
    alloc(2'b00, 32'h1234_567F, 7'd4, 1);
    chk("R1", "ack/slot/tag", {alloc_ack, alloc_err, alloc_slot, alloc_tag}, {1'b1, 1'b0, 2'd0, 8'd0});
    chk("R6", "req with cause 0", {mem_req, mem_req_cause}, 2'b10);
    peek(0, 0);
    chk("R1", "aligned addr", rd_addr, 32'h1234_5640);
    chk("R1", "block size", rd_size, 64);
    alloc(2'b01, 32'h0000_1003, 7'd2, 0);
    chk("R6", "no req without flag", mem_req, 0);
    chk("R4", "tag 1", alloc_tag, 1);
    peek(0, 1);
    chk("R2", "exact addr/size", {rd_addr, rd_size}, {32'h0000_1003, 7'd2});
    alloc(2'b10, 32'h0000_0088, 7'd8, 1);
    chk("R6", "req with cause 1", {mem_req, mem_req_cause}, 2'b11);
    peek(1, 0);
    chk("R3", "write entry", {rd_valid, rd_addr, rd_size, rd_tag}, {1'b1, 32'h88, 7'd8, 8'd2});
    alloc(2'b11, 32'h40, 7'd4, 1);
    chk("R9", "illegal kind rejected", {alloc_ack, alloc_err, mem_req}, 3'b010);
  endtask

  task automatic t_fill_miss();
    alloc(2'b00, 32'h2000, 7'd1, 0);
    chk("R4", "tag skips rejection", alloc_tag, 3);
    chk("R5", "not yet blocked", blocked_mask, 0);
    alloc(2'b00, 32'h3000, 7'd1, 0);
    chk("R5", "miss bit set", {blocked_mask, cpu_stall}, 3'b011);
    chk("R11", "miss events", miss_blk_events, 1);
    alloc(2'b01, 32'h4000, 7'd1, 0);
    chk("R9", "full queue rejects", {alloc_ack, alloc_err}, 2'b01);
    idle(3);
    chk("R10", "no retry while blocked", cpu_retry, 0);
    issue(0, 2);
    chk("R7", "full to not full clears", {blocked_mask, cpu_stall}, 0);
    chk("R10", "retry pulse", cpu_retry, 1);
    chk("R11", "miss cycles", miss_blk_cycles, 5);
    idle(1);
    chk("R10", "retry one cycle", cpu_retry, 0);
  endtask

  task automatic t_fill_wb();
    alloc(2'b10, 32'h100, 7'd4, 0);
    chk("R5", "wb bit set", {blocked_mask, cpu_stall}, 3'b101);
    free_e(1, 0);
    peek(1, 0);
    chk("R8", "free of waiting ignored", rd_valid, 1);
    chk("R8", "free keeps mask", blocked_mask, 2'b10);
    issue(1, 0);
    chk("R7", "wb bit cleared", blocked_mask, 0);
    chk("R10", "no retry without rejection", cpu_retry, 0);
    chk("R11", "wb events/cycles", {wb_blk_events, wb_blk_cycles}, {16'd1, 16'd2});
  endtask

  task automatic t_inservice();
    issue(0, 3);
    chk("R7", "issue on non-full queue", blocked_mask, 0);
    free_e(0, 2);
    peek(0, 2);
    chk("R8", "free of in-service entry", rd_valid, 0);
    alloc(2'b00, 32'h5555_5555, 7'd3, 0);
    chk("R4", "slot 2 tag 6", {alloc_slot, alloc_tag}, {2'd2, 8'd6});
    chk("R5", "three waiting, not blocked", blocked_mask, 0);
    alloc(2'b00, 32'h6000, 7'd1, 0);
    chk("R9", "no free slot rejects", {alloc_ack, alloc_err, blocked_mask}, 4'b0100);
    free_e(0, 3);
    alloc(2'b00, 32'h7000, 7'd1, 0);
    chk("R4", "slot 3 tag 7", {alloc_slot, alloc_tag}, {2'd3, 8'd7});
    chk("R11", "second miss block", {blocked_mask, miss_blk_events}, {2'b01, 16'd2});
    chk("R10", "no retry", cpu_retry, 0);
  endtask

  initial begin
    t_reset();
    t_kinds();
    t_fill_miss();
    t_fill_wb();
    t_inservice();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule